// File: doc/BRIEF.md
# Pre/Post Trigger Capture Sequencer

This block steers writes into a sample memory around a trigger event. After a start strobe it loads the two depth settings and writes every valid sample into a ring of addresses. The ring starts at address 0 and spans the pre-trigger and post-trigger windows together. Once the pre-trigger window has been filled once, the block is armed. The first valid sample that arrives with the trigger input high becomes the first post-trigger sample. After the programmed post-trigger count has been written, the block raises its done bit, stops writing and holds its state until the next start.

Depths are programmed in blocks of 256 samples with a minus-one encoding. Small or oversized settings are clamped so that a capture always fits the memory. Because the whole capture is one ring, the write address left on the output at completion points at the oldest kept sample. A host can read the memory out in time order from there. Post-trigger progress is reported as the number of completed 256-sample blocks. The memory itself, trigger detection and readout sit outside this block.

Top module: `capture_seq`

## Requirements
- R1: After reset and until the first start strobe, the block writes nothing. The status word reads 0, the block count reads 0 and the write address reads 0.
- R2: A pre-depth value y keeps (y+1)*256 samples ahead of the trigger. A post-depth value x records (x+1)*256 samples from the trigger sample onward.
- R3: A depth value of 0 is treated as 1, so each window is at least 512 samples.
- R4: With M = 2^(ADDR_W-8) memory blocks, the pre window is limited to M-2 blocks. The post window is then cut to the blocks that remain, so the two windows together never exceed the memory.
- R5: While a capture runs, wr_en_o equals smp_vld_i. The k-th written sample (counting from 0) goes to address k mod L, where L is the sum of the two window lengths in samples.
- R6: The trigger input is ignored until the pre window has been written once, and it is ignored on cycles without a valid sample.
- R7: The sample that carries the accepted trigger is written as the first post-trigger sample. Status bit 1 (triggered) reads 1 from the next cycle until the next start.
- R8: blocks_o equals the number of post-trigger samples written so far divided by 256, rounded down. At completion it equals the post window in blocks.
- R9: When the last post-trigger sample has been written, status bit 3 (done) reads 1 from the next cycle. From then on wr_en_o stays 0 and wr_addr_o holds (address of last write + 1) mod L until the next start.
- R10: A start strobe restarts the block from any state. The cycle carrying the strobe writes nothing. On the next cycle the status, block count and write address all read 0, and the next valid sample goes to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe; loads depths and restarts capture |
| smp_vld_i | input | 1 | A sample is present this cycle |
| trig_i | input | 1 | Trigger condition from the external detector |
| pre_depth_i | input | DEPTH_W | Pre-trigger depth, blocks minus one |
| post_depth_i | input | DEPTH_W | Post-trigger depth, blocks minus one |
| wr_en_o | output | 1 | Sample memory write enable |
| wr_addr_o | output | ADDR_W | Sample memory write address |
| status_o | output | 4 | Bit 1 triggered, bit 3 done, others 0 |
| blocks_o | output | ADDR_W-BLK_LOG2+1 | Completed post-trigger blocks of 256 samples |

## Verification
A wrong fill count shows up on the first sample after the pre window. The triggered bit then rises too early or too late, and the post-trigger count shifts, so both status and blocks_o differ from the expected value within one cycle of the trigger. A wrong ring length or pointer wrap shows up at the first wrap, where the write address departs from k mod L. The bench compares every write address against that formula. A stale done state or a missed restart shows up the very next cycle, as a write enable on a valid sample or as nonzero status after a start.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_ARMED,
    ST_POST,
    ST_DONE
  } cseq_state_e;

  localparam int STAT_W        = 4;
  localparam int STAT_TRIG_BIT = 1;
  localparam int STAT_DONE_BIT = 3;

  // Pre window in blocks: raw value clamped to [1, mem_blks-3], plus one.
  function automatic logic [31:0] pre_blocks(input logic [31:0] raw,
                                             input logic [31:0] mem_blks);
    logic [31:0] v;
    v = (raw < 32'd1) ? 32'd1 : raw;
    if (v > mem_blks - 32'd3) v = mem_blks - 32'd3;
    return v + 32'd1;
  endfunction

  // Post window in blocks: clamped raw plus one, cut to the room left.
  function automatic logic [31:0] post_blocks(input logic [31:0] raw,
                                              input logic [31:0] pre_blk,
                                              input logic [31:0] mem_blks);
    logic [31:0] v;
    logic [31:0] room;
    v    = (raw < 32'd1) ? 32'd1 : raw;
    room = mem_blks - pre_blk;
    return (v >= room) ? room : v + 32'd1;
  endfunction

endpackage

// File: rtl/cseq_cfg.sv
module cseq_cfg #(
  parameter int DEPTH_W  = 16,
  parameter int ADDR_W   = 12,
  parameter int BLK_LOG2 = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [DEPTH_W-1:0]  pre_depth_i,
  input  logic [DEPTH_W-1:0]  post_depth_i,
  output logic [ADDR_W:0]     pre_len_o,
  output logic [ADDR_W:0]     post_len_o,
  output logic [ADDR_W-1:0]   ring_last_o
);
  import cseq_pkg::*;

  localparam int CNT_W    = ADDR_W + 1;
  localparam int MEM_BLKS = 1 << (ADDR_W - BLK_LOG2);
  localparam int MEM_LEN  = 1 << ADDR_W;
  localparam int MIN_LEN  = 2 << BLK_LOG2;

  logic [CNT_W-1:0]  pre_len_d, post_len_d, ring_len_d;

  always_comb begin
    pre_len_d  = CNT_W'(pre_blocks(32'(pre_depth_i), 32'(MEM_BLKS)) << BLK_LOG2);
    post_len_d = CNT_W'(post_blocks(32'(post_depth_i),
                                    pre_blocks(32'(pre_depth_i), 32'(MEM_BLKS)),
                                    32'(MEM_BLKS)) << BLK_LOG2);
    ring_len_d = pre_len_d + post_len_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_len_o   <= CNT_W'(MIN_LEN);
      post_len_o  <= CNT_W'(MIN_LEN);
      ring_last_o <= ADDR_W'(2 * MIN_LEN - 1);
    end else if (load_i) begin
      pre_len_o   <= pre_len_d;
      post_len_o  <= post_len_d;
      ring_last_o <= ADDR_W'(ring_len_d - CNT_W'(1));
    end
  end

  AST_MIN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_len_o >= CNT_W'(MIN_LEN)) && (post_len_o >= CNT_W'(MIN_LEN))); // R3

  AST_FITS_MEMORY: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, pre_len_o} + {1'b0, post_len_o}) <= (CNT_W+1)'(MEM_LEN)); // R4

endmodule

// File: rtl/cseq_ptr.sv
module cseq_ptr #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] ring_last_i,
  output logic [ADDR_W-1:0] ptr_o
);

  logic at_end;
  assign at_end = (ptr_o == ring_last_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_o <= '0;
    else if (clr_i)  ptr_o <= '0;
    else if (adv_i)  ptr_o <= at_end ? '0 : ptr_o + ADDR_W'(1);
  end

  AST_PTR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_o <= ring_last_i); // R5

endmodule

// File: rtl/cseq_ctrl.sv
module cseq_ctrl #(
  parameter int ADDR_W   = 12,
  parameter int BLK_LOG2 = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic                         smp_vld_i,
  input  logic                         trig_i,
  input  logic [ADDR_W:0]              pre_len_i,
  input  logic [ADDR_W:0]              post_len_i,
  output logic                         wr_en_o,
  output logic                         trig_evt_o,
  output logic [cseq_pkg::STAT_W-1:0]  status_o,
  output logic [ADDR_W-BLK_LOG2:0]     blocks_o
);
  import cseq_pkg::*;

  localparam int CNT_W = ADDR_W + 1;

  cseq_state_e      state_q, state_d;
  logic [CNT_W-1:0] fill_cnt_q, post_cnt_q;
  logic             capturing, fill_inc, post_inc, fill_last, post_last;

  assign capturing  = state_q inside {ST_FILL, ST_ARMED, ST_POST};
  assign wr_en_o    = capturing && smp_vld_i && !start_i;
  assign fill_inc   = wr_en_o && (state_q == ST_FILL);
  assign fill_last  = fill_inc && (fill_cnt_q + CNT_W'(1) == pre_len_i);
  assign trig_evt_o = wr_en_o && (state_q == ST_ARMED) && trig_i;
  assign post_inc   = trig_evt_o || (wr_en_o && (state_q == ST_POST));
  assign post_last  = post_inc && (post_cnt_q + CNT_W'(1) == post_len_i);

  always_comb begin
    state_d = state_q;
    if (start_i) begin
      state_d = ST_FILL;
    end else begin
      case (state_q)
        ST_FILL:  if (fill_last)  state_d = ST_ARMED;
        ST_ARMED: if (trig_evt_o) state_d = post_last ? ST_DONE : ST_POST;
        ST_POST:  if (post_last)  state_d = ST_DONE;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      fill_cnt_q <= '0;
      post_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (start_i) begin
        fill_cnt_q <= '0;
        post_cnt_q <= '0;
      end else begin
        if (fill_inc) fill_cnt_q <= fill_cnt_q + CNT_W'(1);
        if (post_inc) post_cnt_q <= post_cnt_q + CNT_W'(1);
      end
    end
  end

  always_comb begin
    status_o                = '0;
    status_o[STAT_TRIG_BIT] = (state_q == ST_POST) || (state_q == ST_DONE);
    status_o[STAT_DONE_BIT] = (state_q == ST_DONE);
  end

  assign blocks_o = post_cnt_q[CNT_W-1:BLK_LOG2];

  AST_ARMED_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED) |-> (fill_cnt_q == pre_len_i)); // R2

  AST_TRIG_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[STAT_TRIG_BIT]) |-> $past(state_q == ST_ARMED)); // R6

  AST_POST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    post_cnt_q <= post_len_i); // R9

endmodule

// File: rtl/capture_seq.sv
module capture_seq #(
  parameter int DEPTH_W  = 16,
  parameter int ADDR_W   = 12,
  parameter int BLK_LOG2 = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     smp_vld_i,
  input  logic                     trig_i,
  input  logic [DEPTH_W-1:0]       pre_depth_i,
  input  logic [DEPTH_W-1:0]       post_depth_i,
  output logic                     wr_en_o,
  output logic [ADDR_W-1:0]        wr_addr_o,
  output logic [3:0]               status_o,
  output logic [ADDR_W-BLK_LOG2:0] blocks_o
);
  import cseq_pkg::*;

  logic [ADDR_W:0]   pre_len, post_len;
  logic [ADDR_W-1:0] ring_last;
  logic              trig_evt;

  cseq_cfg #(.DEPTH_W(DEPTH_W), .ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (start_i),
    .pre_depth_i  (pre_depth_i),
    .post_depth_i (post_depth_i),
    .pre_len_o    (pre_len),
    .post_len_o   (post_len),
    .ring_last_o  (ring_last)
  );

  cseq_ctrl #(.ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .smp_vld_i  (smp_vld_i),
    .trig_i     (trig_i),
    .pre_len_i  (pre_len),
    .post_len_i (post_len),
    .wr_en_o    (wr_en_o),
    .trig_evt_o (trig_evt),
    .status_o   (status_o),
    .blocks_o   (blocks_o)
  );

  cseq_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (start_i),
    .adv_i       (wr_en_o),
    .ring_last_i (ring_last),
    .ptr_o       (wr_addr_o)
  );

  AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[STAT_DONE_BIT] |-> !wr_en_o); // R9

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[STAT_DONE_BIT] && !start_i) |=> (status_o[STAT_DONE_BIT] && $stable(wr_addr_o))); // R9

  AST_TRIG_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_evt && !status_o[STAT_TRIG_BIT]) |=> status_o[STAT_TRIG_BIT]); // R7

  AST_BLK_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (blocks_o >= $past(blocks_o))); // R8

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (status_o == 4'd0 && blocks_o == '0 && wr_addr_o == '0)); // R10

endmodule

// File: tb/test_capture_seq.sv
module test_capture_seq;
  localparam int CLK_PERIOD = 10;
  localparam int BLK        = 256;
  localparam int NV         = 5;
  // pre reg, post reg, trigger sample index, expected pre blocks, expected post blocks
  localparam int VEC [NV][5] = '{
    '{ 1, 1,  600,  2, 2},
    '{ 0, 0,  512,  2, 2},
    '{ 3, 2,  100,  4, 3},
    '{13, 9, 4000, 14, 2},
    '{20, 0, 3700, 14, 2}
  };

  logic        clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, smp_vld_i = 1'b0, trig_i = 1'b0;
  logic [15:0] pre_depth_i = '0, post_depth_i = '0;
  logic        wr_en_o;
  logic [11:0] wr_addr_o;
  logic [3:0]  status_o;
  logic [4:0]  blocks_o;

  int errors = 0, checks = 0;
  logic ow;
  int oa, os, ob;

  always #(CLK_PERIOD/2) clk = ~clk;

  capture_seq i_capture_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .smp_vld_i(smp_vld_i), .trig_i(trig_i),
    .pre_depth_i(pre_depth_i), .post_depth_i(post_depth_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .status_o(status_o), .blocks_o(blocks_o)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic t, input logic s);
    @(negedge clk);
    smp_vld_i = v; trig_i = t; start_i = s;
    #1;
    ow = wr_en_o; oa = int'(wr_addr_o); os = int'(status_o); ob = int'(blocks_o);
  endtask

  task automatic run_vec(input int vi);
    int pre, post, tidx, preb, postb, L, prel, postl, ts, idx, c;
    int bad_en, bad_addr, bad_st, bad_bl, hold_en, hold_st, hold_bl, hold_addr;
    string tag, stag;
    logic v;
    pre = VEC[vi][0]; post = VEC[vi][1]; tidx = VEC[vi][2];
    preb = VEC[vi][3]; postb = VEC[vi][4];
    tag  = (vi == 1) ? "R3" : ((vi >= 3) ? "R4" : "R2");
    stag = (vi == 2) ? "R6" : "R7";
    L = (preb + postb) * BLK; prel = preb * BLK; postl = postb * BLK;
    ts = (tidx > prel) ? tidx : prel;
    pre_depth_i = 16'(pre); post_depth_i = 16'(post);
    step(1'b0, 1'b0, 1'b1);
    idx = 0; c = 0; bad_en = 0; bad_addr = 0; bad_st = 0; bad_bl = 0;
    while (idx < ts + postl && c < 20000) begin
      v = ((c % 4) != 3);
      step(v, idx >= tidx, 1'b0);
      if (ow !== v) bad_en++;
      if (os != ((idx > ts) ? 2 : 0)) bad_st++;
      if (ob != ((idx > ts) ? (idx - ts) / BLK : 0)) bad_bl++;
      if (ow) begin
        if (oa != idx % L) bad_addr++;
        idx++;
      end
      c++;
    end
    check(bad_en == 0,   "R5", "write enable follows valid", bad_en, 0);
    check(bad_addr == 0, "R5", "ring addresses", bad_addr, 0);
    check(bad_st == 0,   stag, "triggered bit timing", bad_st, 0);
    check(bad_bl == 0,   "R8", "running block count", bad_bl, 0);
    check(idx == ts + postl, tag, "samples written", idx, ts + postl);
    hold_en = 0; hold_st = 0; hold_bl = 0; hold_addr = 0;
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b1, 1'b0);
      if (ow) hold_en++;
      if (os != 10) hold_st++;
      if (ob != postb) hold_bl++;
      if (oa != (ts + postl) % L) hold_addr++;
    end
    check(hold_en == 0,   "R9", "no writes after done", hold_en, 0);
    check(hold_st == 0,   "R9", "done status held", os, 10);
    check(hold_bl == 0,   tag,  "final post blocks", ob, postb);
    check(hold_addr == 0, "R9", "address at oldest sample", oa, (ts + postl) % L);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++; checks++;
    $display("FAIL R9 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int bad;
    // R1: reset state and no writes before a start
    step(1'b1, 1'b1, 1'b0);
    check(ow == 1'b0 && os == 0 && ob == 0 && oa == 0, "R1", "state in reset", os + ob + oa + int'(ow), 0);
    @(negedge clk); rst_n = 1'b1;
    bad = 0;
    for (int k = 0; k < 5; k++) begin
      step(1'b1, 1'b1, 1'b0);
      if (ow || os != 0 || ob != 0 || oa != 0) bad++;
    end
    check(bad == 0, "R1", "idle before start", bad, 0);

    for (int vi = 0; vi < NV; vi++) run_vec(vi);

    // R6: trigger without a valid sample is ignored
    pre_depth_i = 16'd1; post_depth_i = 16'd1;
    step(1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 512; k++) step(1'b1, 1'b0, 1'b0);
    bad = 0;
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 1'b1, 1'b0);
      if (os != 0 || ow) bad++;
    end
    for (int k = 0; k < 10; k++) begin
      step(1'b1, 1'b0, 1'b0);
      if (os != 0 || ob != 0) bad++;
    end
    check(bad == 0, "R6", "trigger without valid ignored", bad, 0);
    step(1'b1, 1'b1, 1'b0);
    check(ow == 1'b1 && oa == 522, "R5", "trigger sample address", oa, 522);
    step(1'b1, 1'b0, 1'b0);
    check(os == 2, "R7", "triggered bit next cycle", os, 2);
    check(ob == 0, "R8", "no block before 256 samples", ob, 0);
    for (int k = 0; k < 254; k++) step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    check(ob == 1, "R8", "one block after 256 samples", ob, 1);

    // R10: restart during the post window
    step(1'b1, 1'b1, 1'b1);
    check(ow == 1'b0, "R10", "no write on start cycle", int'(ow), 0);
    step(1'b0, 1'b0, 1'b0);
    check(os == 0 && ob == 0, "R10", "status and count cleared", os + ob, 0);
    check(oa == 0, "R10", "address cleared", oa, 0);
    step(1'b1, 1'b0, 1'b0);
    check(ow == 1'b1 && oa == 0, "R10", "first write at 0", oa, 0);
    step(1'b1, 1'b0, 1'b0);
    check(oa == 1, "R5", "second write at 1", oa, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule